// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker turns a 32-bit device virtual address into a physical address by reading descriptors from a two-level page table kept in memory. For each request it fetches one first-level descriptor. That descriptor either maps a 1 MiB section directly or points to a second-level table. When it points to a table, the walker fetches one second-level descriptor, which maps a 64 KiB large page or a 4 KiB small page. A descriptor that maps nothing ends the walk with a fault response.

A mode input selects between a 32-bit physical space and an extended 36-bit space. In the extended space, every stored descriptor holds its address moved four bits to the right. The walker moves every base it takes from a descriptor, including the pointer to the second-level table, back to the left before using it. The block handles one walk at a time. Requests arrive on a valid/ready port, and results leave on a valid/ready port. Memory is reached through one read channel that has at most one read outstanding: the read request uses a valid/ready handshake, and the read data comes back on a one-cycle valid pulse.

Top module: `xlat_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_rd_valid is 0.
- R2: The first read of a walk goes to address l1_base + 4 * va[31:20], and this address is computed modulo 2^36.
- R3: A first-level descriptor whose bits [1:0] are 2'b10 maps a section. The walk then ends after that single read, and rsp_pa = {X[35:20], va[19:0]}, where X is the widened descriptor.
- R4: A first-level descriptor whose bits [1:0] are 2'b01 starts a second read. That read goes to address widen(descriptor & 32'hFFFFFFC0) + 4 * va[19:12].
- R5: A second-level descriptor whose bits [1:0] are 2'b01 maps a large page: rsp_pa = {Y[35:16], va[15:0]}, where Y is the widened second-level descriptor.
- R6: A second-level descriptor whose bit 1 is set (bits [1:0] 2'b10 or 2'b11) maps a small page: rsp_pa = {Y[35:12], va[11:0]}.
- R7: A descriptor whose bits [1:0] are 2'b00, at either level, gives rsp_fault = 1 and rsp_pa = 0. A first-level descriptor with bits [1:0] 2'b11 also faults. A fault at the first level issues no second read.
- R8: Widening maps a 32-bit descriptor d to {d, 4'b0} when the ext_mode sampled at request acceptance is 1, and to {4'b0, d} when it is 0. Changes to ext_mode after acceptance do not affect the walk in progress.
- R9: req_ready stays 0 from request acceptance until the response handshake completes. While rsp_ready is 0, rsp_valid, rsp_fault and rsp_pa stay constant.
- R10: While mem_rd_ready is 0, mem_rd_valid stays 1 and mem_rd_addr stays unchanged. Read addresses are always multiples of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_mode | input | 1 | 1: 36-bit physical space with descriptors shifted by 4 |
| l1_base | input | 36 | Physical base of the first-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Result accepted |
| rsp_fault | output | 1 | Walk ended on an invalid descriptor |
| rsp_pa | output | 36 | Translated physical address (0 on fault) |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 36 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data valid (one cycle) |
| mem_rsp_data | input | 32 | Descriptor word |

## Verification
Two situations are hard to reach from the ports. The first is a walk in the extended mode whose mode input changes while the walk is under way. The second is a second-level table pointer whose low six bits are nonzero and must be discarded before the shift. The bench toggles ext_mode in the cycle after every request is accepted, so a walker that reads the live input instead of its latched copy computes the wrong address. Several first-level vectors carry stray low bits, and the bench checks the exact second-level read address. The bench also stalls the read handshake and the response handshake for several cycles, so it can observe that the held values stay stable.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int VA_W        = 32;
    localparam int DESC_W      = 32;
    localparam int EXT_SHIFT   = 4;
    localparam int PA_W        = DESC_W + EXT_SHIFT;
    localparam int SECT_OFF_W  = 20;
    localparam int LARGE_OFF_W = 16;
    localparam int SMALL_OFF_W = 12;
    localparam int ENT_BYTES_W = 2;
    localparam int PTR_LOW_W   = 6;
    localparam int L1_IDX_W    = VA_W - SECT_OFF_W;
    localparam int L2_IDX_W    = SECT_OFF_W - SMALL_OFF_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_RESP
    } walk_state_e;

    typedef enum logic [1:0] {
        K_FAULT, K_SECTION, K_TABLE
    } l1_kind_e;

    typedef struct packed {
        walk_state_e            state;
        logic [SECT_OFF_W-1:0]  va_lo;
        logic                   ext;
        logic [PA_W-1:0]        rd_addr;
        logic [PA_W-1:0]        pa;
        logic                   fault;
    } walk_regs_t;

    // Restore a stored descriptor value to a physical address.
    function automatic logic [PA_W-1:0] widen(input logic [DESC_W-1:0] d, input logic ext);
        logic [PA_W-1:0] w;
        w = {{EXT_SHIFT{1'b0}}, d};
        return ext ? (w << EXT_SHIFT) : w;
    endfunction

    // Page base from descriptor combined with in-page offset.
    function automatic logic [PA_W-1:0] join_offset(input logic [PA_W-1:0] base,
                                                    input logic [PA_W-1:0] offs,
                                                    input int off_w);
        logic [PA_W-1:0] m;
        m = ({{(PA_W-1){1'b0}}, 1'b1} << off_w) - 1'b1;
        return (base & ~m) | (offs & m);
    endfunction
endpackage

// File: rtl/xw_l1_decode.sv
module xw_l1_decode
    import xw_pkg::*;
(
    input  logic [DESC_W-1:0]     desc_i,
    input  logic                  ext_i,
    input  logic [SECT_OFF_W-1:0] va_lo_i,
    output l1_kind_e              kind_o,
    output logic [PA_W-1:0]       sect_pa_o,
    output logic [PA_W-1:0]       l2_addr_o
);
    logic [DESC_W-1:0] ptr_raw;
    logic [PA_W-1:0]   l2_base;
    logic [PA_W-1:0]   l2_off;

    always_comb begin
        unique case (desc_i[1:0])
            2'b10:   kind_o = K_SECTION;
            2'b01:   kind_o = K_TABLE;
            default: kind_o = K_FAULT;
        endcase
        sect_pa_o = join_offset(widen(desc_i, ext_i),
                                {{(PA_W-SECT_OFF_W){1'b0}}, va_lo_i}, SECT_OFF_W);
        ptr_raw   = {desc_i[DESC_W-1:PTR_LOW_W], {PTR_LOW_W{1'b0}}};
        l2_base   = widen(ptr_raw, ext_i);
        l2_off    = {{(PA_W-L2_IDX_W-ENT_BYTES_W){1'b0}},
                     va_lo_i[SECT_OFF_W-1:SMALL_OFF_W], {ENT_BYTES_W{1'b0}}};
        l2_addr_o = l2_base + l2_off;
    end
endmodule

// File: rtl/xw_l2_decode.sv
module xw_l2_decode
    import xw_pkg::*;
(
    input  logic [DESC_W-1:0]      desc_i,
    input  logic                   ext_i,
    input  logic [LARGE_OFF_W-1:0] va_lo_i,
    output logic                   fault_o,
    output logic [PA_W-1:0]        page_pa_o
);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] offs;

    always_comb begin
        base    = widen(desc_i, ext_i);
        offs    = {{(PA_W-LARGE_OFF_W){1'b0}}, va_lo_i};
        fault_o = (desc_i[1:0] == 2'b00);
        if (desc_i[1:0] == 2'b01)
            page_pa_o = join_offset(base, offs, LARGE_OFF_W);
        else
            page_pa_o = join_offset(base, offs, SMALL_OFF_W);
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic [PA_W-1:0]   l1_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data
);
    walk_regs_t r_d, r_q;

    l1_kind_e        l1_kind;
    logic [PA_W-1:0] l1_sect_pa;
    logic [PA_W-1:0] l1_next_addr;
    logic            l2_fault;
    logic [PA_W-1:0] l2_pa;
    logic [PA_W-1:0] l1_off;

    xw_l1_decode u_l1 (
        .desc_i    (mem_rsp_data),
        .ext_i     (r_q.ext),
        .va_lo_i   (r_q.va_lo),
        .kind_o    (l1_kind),
        .sect_pa_o (l1_sect_pa),
        .l2_addr_o (l1_next_addr)
    );

    xw_l2_decode u_l2 (
        .desc_i    (mem_rsp_data),
        .ext_i     (r_q.ext),
        .va_lo_i   (r_q.va_lo[LARGE_OFF_W-1:0]),
        .fault_o   (l2_fault),
        .page_pa_o (l2_pa)
    );

    assign l1_off = {{(PA_W-L1_IDX_W-ENT_BYTES_W){1'b0}},
                     req_va[VA_W-1:SECT_OFF_W], {ENT_BYTES_W{1'b0}}};

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va_lo   = req_va[SECT_OFF_W-1:0];
                    r_d.ext     = ext_mode;
                    r_d.rd_addr = l1_base + l1_off;
                    r_d.state   = ST_L1_REQ;
                end
            end
            ST_L1_REQ: if (mem_rd_ready) r_d.state = ST_L1_WAIT;
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (l1_kind)
                        K_SECTION: begin
                            r_d.pa    = l1_sect_pa;
                            r_d.fault = 1'b0;
                            r_d.state = ST_RESP;
                        end
                        K_TABLE: begin
                            r_d.rd_addr = l1_next_addr;
                            r_d.state   = ST_L2_REQ;
                        end
                        default: begin
                            r_d.pa    = '0;
                            r_d.fault = 1'b1;
                            r_d.state = ST_RESP;
                        end
                    endcase
                end
            end
            ST_L2_REQ: if (mem_rd_ready) r_d.state = ST_L2_WAIT;
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.fault = l2_fault;
                    r_d.pa    = l2_fault ? '0 : l2_pa;
                    r_d.state = ST_RESP;
                end
            end
            ST_RESP: if (rsp_ready) r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, va_lo: '0, ext: 1'b0, rd_addr: '0, pa: '0, fault: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.state == ST_IDLE);
    assign rsp_valid    = (r_q.state == ST_RESP);
    assign rsp_fault    = r_q.fault;
    assign rsp_pa       = r_q.pa;
    assign mem_rd_valid = (r_q.state == ST_L1_REQ) || (r_q.state == ST_L2_REQ);
    assign mem_rd_addr  = r_q.rd_addr;

    // R9: the response holds until accepted
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault));

    // R9: no new request is taken while a result is pending
    a_r9_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    // R10: a read request holds until accepted
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // R10: descriptor reads are word aligned
    a_r10_rd_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00);

    // R7: a fault response carries no address
    a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_pa == '0);

    // R8: the 32-bit space never produces upper address bits from a descriptor
    a_r8_legacy_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) && !r_q.ext |-> rsp_pa[PA_W-1:DESC_W] == '0);
endmodule

// File: tb/xlat_walker_tb_top.sv
module xlat_walker_tb_top;
    typedef struct packed {
        logic        ext;
        logic [31:0] va;
        logic [31:0] d1;
        logic [31:0] d2;
        logic        exp_fault;
        logic [1:0]  exp_reads;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 32'h12345678, 32'hABC00002, 32'h00000000, 1'b0, 2'd1},
        '{1'b1, 32'h12345678, 32'hABC00002, 32'h00000000, 1'b0, 2'd1},
        '{1'b0, 32'h00ABCDEF, 32'h00123441, 32'h55660001, 1'b0, 2'd2},
        '{1'b1, 32'hFFF1F2F3, 32'h0F00FFC1, 32'h77770001, 1'b0, 2'd2},
        '{1'b0, 32'h7654A321, 32'h30000401, 32'h99999002, 1'b0, 2'd2},
        '{1'b1, 32'hFFFFFFFF, 32'hFFFFFFC1, 32'hFFFFF003, 1'b0, 2'd2},
        '{1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 2'd1},
        '{1'b1, 32'h80000000, 32'h12345673, 32'h00000000, 1'b1, 2'd1},
        '{1'b0, 32'h11122333, 32'h20000001, 32'h00001000, 1'b1, 2'd2},
        '{1'b1, 32'h000ABCDE, 32'hFFF00002, 32'h00000000, 1'b0, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic [35:0] l1_base = 36'h0_4000_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [35:0] rsp_pa;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b1;
    logic [35:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    xlat_walker dut_i (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .l1_base(l1_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_pa(rsp_pa), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] wide(input logic [31:0] d, input logic e);
        return e ? {d, 4'h0} : {4'h0, d};
    endfunction

    task automatic walk(input vec_t v, input logic [35:0] base, input int rd_stall,
                        input int rsp_delay);
        logic [35:0] e_l1, e_l2, e_pa, x, seen_addr, held_pa;
        logic held_f;
        int reads, stall, waited;
        bit pend, done, have_addr;
        logic [31:0] pdata;
        e_l1 = base + {22'd0, v.va[31:20], 2'b00};
        x    = wide(v.d1, v.ext);
        e_l2 = wide({v.d1[31:6], 6'd0}, v.ext) + {26'd0, v.va[19:12], 2'b00};
        if (v.exp_fault) e_pa = '0;
        else if (v.d1[1:0] == 2'b10) e_pa = {x[35:20], v.va[19:0]};
        else begin
            x = wide(v.d2, v.ext);
            if (v.d2[1:0] == 2'b01) e_pa = {x[35:16], v.va[15:0]};
            else e_pa = {x[35:12], v.va[11:0]};
        end
        @(negedge clk);
        l1_base = base; ext_mode = v.ext; req_va = v.va; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ext_mode = ~v.ext;  // R8: mode change after acceptance must not matter
        chk(req_ready == 1'b0, "R9 busy after accept", {35'd0, req_ready}, 36'd0);
        reads = 0; pend = 0; stall = rd_stall; done = 0; waited = 0; have_addr = 0;
        held_pa = '0; held_f = 0; seen_addr = '0; pdata = '0;
        for (int c = 0; c < 60 && !done; c++) begin
            mem_rsp_valid = 1'b0;
            mem_rd_ready = 1'b1;
            if (pend) begin
                mem_rsp_valid = 1'b1; mem_rsp_data = pdata; pend = 0;
            end
            if (mem_rd_valid) begin
                if (have_addr)
                    chk(mem_rd_addr == seen_addr, "R10 addr held", mem_rd_addr, seen_addr);
                if (stall > 0) begin
                    mem_rd_ready = 1'b0; stall--;
                    seen_addr = mem_rd_addr; have_addr = 1;
                end else begin
                    if (reads == 0)
                        chk(mem_rd_addr == e_l1, "R2 first-level address", mem_rd_addr, e_l1);
                    else
                        chk(mem_rd_addr == e_l2, "R4 second-level address", mem_rd_addr, e_l2);
                    pdata = (reads == 0) ? v.d1 : v.d2;
                    pend = 1; reads++; have_addr = 0;
                    stall = rd_stall;
                end
            end
            if (rsp_valid) begin
                chk(req_ready == 1'b0, "R9 no accept while result pending", {35'd0, req_ready}, 36'd0);
                if (waited > 0)
                    chk(rsp_pa == held_pa && rsp_fault == held_f, "R9 result held", rsp_pa, held_pa);
                held_pa = rsp_pa; held_f = rsp_fault;
                if (waited < rsp_delay) begin
                    rsp_ready = 1'b0; waited++;
                end else begin
                    chk(rsp_fault == v.exp_fault, "R7 fault flag", {35'd0, rsp_fault}, {35'd0, v.exp_fault});
                    chk(rsp_pa == e_pa, "R3/R5/R6/R8 physical address", rsp_pa, e_pa);
                    rsp_ready = 1'b1; done = 1;
                end
            end
            @(negedge clk);
        end
        rsp_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rd_ready = 1'b1;
        chk(done, "R9 walk completed", {35'd0, done}, 36'd1);
        chk(reads == int'(v.exp_reads), "R3/R4/R7 descriptor read count", 36'(reads), 36'(v.exp_reads));
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R9 idle after handshake",
            {34'd0, req_ready, rsp_valid}, 36'd2);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_valid == 1'b0, "R1 reset outputs",
            {33'd0, req_ready, rsp_valid, mem_rd_valid}, 36'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_rd_valid == 1'b0, "R1 idle after reset",
            {34'd0, req_ready, mem_rd_valid}, 36'd2);

        // Vector table: sections, pages, faults in both modes
        for (int i = 0; i < NV; i++)
            walk(VECS[i], 36'h0_4000_0000, i % 3, (i + 1) % 3);

        // R2: table base in the upper physical range, index wraps to top entry
        walk('{1'b1, 32'hFFF00000, 32'h00100002, 32'h0, 1'b0, 2'd1}, 36'hF_FFFF_F000, 0, 0);
        // R6: small page with bit pattern 2'b10 in the 32-bit space, long stalls
        walk('{1'b0, 32'h00001FFF, 32'h00000001, 32'hFFFFF002, 1'b0, 2'd2}, 36'h0_0000_0000, 4, 5);
        // R7: second-level fault in the extended space
        walk('{1'b1, 32'h00300000, 32'hFFFFFF81, 32'hFFFFFFFC, 1'b1, 2'd2}, 36'h8_0000_0000, 1, 0);
        // R5: large page whose offset uses all 16 bits
        walk('{1'b1, 32'h0040FFFF, 32'h00000041, 32'hFFFF0001, 1'b0, 2'd2}, 36'h1_0000_0000, 0, 2);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule